// File: doc/BRIEF.md
# Transactional access buffer controller

This block sits between one processor and a shared, word-addressed memory and lets the processor group several reads and writes into one all-or-nothing transaction. Each location touched by a transaction occupies one entry of a small fully associative buffer. The entry holds the address, the value memory had when the location was first touched, the tentative new value, and whether the location belongs to the write set. Every valid entry counts as a read-set location.

A snoop input reports reads and writes made by other agents. An outside write to any tracked address dooms the transaction. An outside read of a write-set address also dooms it. The doom is kept in a sticky status flag. At commit time that flag decides between two outcomes. On success, every write-set entry is copied to memory, one entry per cycle. On failure, the buffer is simply emptied. In both cases the next transaction starts from a clean buffer. The buffer has a fixed number of entries, and a transaction that needs more fails.

Top module: `txbuf_ctrl`

## Requirements
- R1: LOAD (op_code 1) of an address not in the buffer returns the memory value at that address in rsp_data. The response comes one cycle after the op is accepted, and the address joins the transaction.
- R2: LOADX (op_code 2) returns the value the same way as LOAD, but places the address in the write set. The address is then written back on a successful commit and is protected against outside reads.
- R3: STORE (op_code 3) records a tentative value in the buffer. Memory is not written before a successful commit.
- R4: A LOAD of an address already in the write set returns the tentative buffered value, not the memory value.
- R5: The transaction is doomed by a snoop write to any tracked address, or by a snoop read of a write-set address. A snoop read of a read-only address, or a snoop of an untracked address, has no effect.
- R6: VALIDATE (op_code 6) responds with rsp_ok=1 while the transaction can still commit, and with rsp_ok=0 once it is doomed.
- R7: A COMMIT (op_code 4) of a live transaction responds with rsp_ok=1. In the same cycle as that response, busy rises. The write-set entries are then written to memory one per cycle, in the order they entered the buffer, and busy stays high for exactly as many cycles as there are write-set entries.
- R8: A COMMIT of a doomed transaction responds with rsp_ok=0 and writes nothing to memory. The buffer is emptied and the status is restored, so the next transaction starts live.
- R9: ABORT (op_code 5) responds with rsp_ok=1, discards all tentative values, leaves memory unchanged and starts a fresh, live transaction.
- R10: The buffer holds DEPTH entries. An access that needs a new entry while all DEPTH are in use dooms the transaction, and its response has rsp_ok=0. For LOAD, rsp_ok on an access response gives the status after that access.
- R11: While busy is high, op_ready is low. An op presented during that time gets no response and has no effect on the buffer.
- R12: After reset, busy, rsp_valid and mem_wr_en are low and op_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented |
| op_code | input | 3 | 0 none, 1 LOAD, 2 LOADX, 3 STORE, 4 COMMIT, 5 ABORT, 6 VALIDATE, 7 none |
| op_addr | input | AW | Word address for LOAD, LOADX and STORE |
| op_wdata | input | DW | Value for STORE |
| op_ready | output | 1 | Operations are accepted (low while draining) |
| rsp_valid | output | 1 | Response for the op accepted in the previous cycle |
| rsp_ok | output | 1 | Transaction status, or commit success |
| rsp_data | output | DW | Load result, zero for other ops |
| snp_valid | input | 1 | Another agent accesses memory this cycle |
| snp_write | input | 1 | The snooped access is a write (1) or a read (0) |
| snp_addr | input | AW | Address of the snooped access |
| mem_rd_addr | output | AW | Address read from memory (combinational response expected) |
| mem_rd_data | input | DW | Memory data at mem_rd_addr, same cycle |
| mem_wr_en | output | 1 | Commit write-back strobe |
| mem_wr_addr | output | AW | Commit write-back address |
| mem_wr_data | output | DW | Commit write-back data |
| busy | output | 1 | Write-back of a committed transaction is in progress |

## Verification
The checker assumes several things about the inputs. Memory answers a read in the same cycle. The processor holds off new ops while op_ready is low, except where the stall itself is being probed. A snoop never names the address that is being entered into the buffer in that same cycle. The bench keeps to these assumptions in three ways. Ops and snoops go out in separate cycles. The address ranges of the sweep do not overlap. The only op presented during a drain is the single one that deliberately probes the stall.

// File: rtl/txbuf_pkg.sv
`timescale 1ns/1ps
// Shared operation encoding for the transactional access buffer.
package txbuf_pkg;
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_LOAD     = 3'd1,
        OP_LOADX    = 3'd2,
        OP_STORE    = 3'd3,
        OP_COMMIT   = 3'd4,
        OP_ABORT    = 3'd5,
        OP_VALIDATE = 3'd6,
        OP_RSVD     = 3'd7
    } op_e;
endpackage

// File: rtl/txbuf_entries.sv
`timescale 1ns/1ps
// Fully associative entry store. Entries are appended in allocation order
// and are only ever cleared all together. Assumes at most one entry per
// address, which holds because allocation happens only on a miss.
module txbuf_entries #(
    parameter int N  = 4,
    parameter int AW = 8,
    parameter int DW = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          acc_en,
    input  logic          acc_store,
    input  logic          acc_mark_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_mem,
    input  logic [DW-1:0] acc_wdata,
    output logic          hit,
    output logic [DW-1:0] hit_val,
    output logic          full,
    output logic [N-1:0]  wset,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_any,
    output logic          snp_wset,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [N-1:0]  vld;
    logic [N-1:0]  wr_f;
    logic [AW-1:0] addr_q [N];
    logic [DW-1:0] old_q  [N];
    logic [DW-1:0] new_q  [N];
    logic [CW-1:0] count;
    logic [N-1:0]  match;
    logic [N-1:0]  snp_m;
    logic [N-1:0]  alloc_sel;

    // Per-entry comparators for lookup, snooping and allocation select.
    for (genvar g = 0; g < N; g++) begin : gen_cmp
        assign match[g]     = vld[g] && (addr_q[g] == acc_addr);
        assign snp_m[g]     = vld[g] && (addr_q[g] == snp_addr);
        assign alloc_sel[g] = acc_en && !hit && (count == CW'(g));
    end

    assign hit      = |match;
    assign full     = (count == CW'(N));
    assign wset     = wr_f;
    assign snp_any  = |snp_m;
    assign snp_wset = |(snp_m & wr_f);
    assign rd_addr  = addr_q[rd_idx];
    assign rd_data  = new_q[rd_idx];

    // Value seen by a load hit: tentative for write-set entries, else old.
    always_comb begin
        hit_val = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) hit_val = hit_val | (wr_f[i] ? new_q[i] : old_q[i]);
        end
    end

    // Occupancy count and per-entry flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vld   <= '0;
            wr_f  <= '0;
            count <= '0;
        end else if (acc_en) begin
            if (!hit && !full) count <= count + CW'(1);
            for (int i = 0; i < N; i++) begin
                if (alloc_sel[i]) begin
                    vld[i]  <= 1'b1;
                    wr_f[i] <= acc_mark_wr;
                end else if (match[i]) begin
                    wr_f[i] <= wr_f[i] | acc_mark_wr;
                end
            end
        end
    end

    // Address, old value and tentative value storage (no reset needed).
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (alloc_sel[i]) begin
                addr_q[i] <= acc_addr;
                old_q[i]  <= acc_mem;
                new_q[i]  <= acc_store ? acc_wdata : acc_mem;
            end else if (acc_en && match[i] && acc_store) begin
                new_q[i] <= acc_wdata;
            end
        end
    end
endmodule

// File: rtl/txbuf_drain.sv
`timescale 1ns/1ps
// Write-back sequencer: holds the mask of entries still to be written and
// selects the lowest one each cycle. Assumes the entry data stays untouched
// while the mask is non-zero (the top stalls new ops).
module txbuf_drain #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [N-1:0]  load_mask,
    output logic          busy,
    output logic [IW-1:0] sel_idx
);
    logic [N-1:0] pend_q;

    assign busy = |pend_q;

    // Lowest pending entry is the next one written.
    always_comb begin
        sel_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_q[i]) sel_idx = IW'(i);
        end
    end

    // Load the write-set mask at commit, then retire one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= '0;
        else if (load_en) pend_q <= load_mask;
        else              pend_q <= pend_q & (pend_q - N'(1));
    end
endmodule

// File: rtl/txbuf_ctrl.sv
`timescale 1ns/1ps
// Transactional access buffer controller. Decodes processor ops, keeps the
// sticky transaction status, folds same-cycle snoop conflicts and capacity
// overflow into it, and launches the write-back on a successful commit.
// Assumes memory returns mem_rd_data for mem_rd_addr in the same cycle.
module txbuf_ctrl #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_wdata,
    output logic          op_ready,
    output logic          rsp_valid,
    output logic          rsp_ok,
    output logic [DW-1:0] rsp_data,
    input  logic          snp_valid,
    input  logic          snp_write,
    input  logic [AW-1:0] snp_addr,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    output logic          busy
);
    import txbuf_pkg::*;

    op_e              op;
    logic             take, is_acc, is_load, is_end, is_commit, known;
    logic             hit, full, snp_any, snp_wset;
    logic [DW-1:0]    hit_val;
    logic [DEPTH-1:0] wset;
    logic [IW-1:0]    sel_idx;
    logic             overflow, conflict, still_ok, drain_go, ok_q;

    assign op        = op_e'(op_code);
    assign take      = op_valid && !busy;
    assign is_load   = (op == OP_LOAD) || (op == OP_LOADX);
    assign is_acc    = take && (is_load || (op == OP_STORE));
    assign is_commit = take && (op == OP_COMMIT);
    assign is_end    = is_commit || (take && (op == OP_ABORT));
    assign known     = (op != OP_NOP) && (op != OP_RSVD);
    assign overflow  = is_acc && !hit && full;
    assign conflict  = snp_valid && (snp_write ? snp_any : snp_wset);
    assign still_ok  = ok_q && !conflict && !overflow;
    assign drain_go  = is_commit && still_ok;

    assign op_ready    = !busy;
    assign mem_rd_addr = op_addr;
    assign mem_wr_en   = busy;

    txbuf_entries #(.N(DEPTH), .AW(AW), .DW(DW)) entries_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (is_end),
        .acc_en     (is_acc),
        .acc_store  (op == OP_STORE),
        .acc_mark_wr(op != OP_LOAD),
        .acc_addr   (op_addr),
        .acc_mem    (mem_rd_data),
        .acc_wdata  (op_wdata),
        .hit        (hit),
        .hit_val    (hit_val),
        .full       (full),
        .wset       (wset),
        .snp_addr   (snp_addr),
        .snp_any    (snp_any),
        .snp_wset   (snp_wset),
        .rd_idx     (sel_idx),
        .rd_addr    (mem_wr_addr),
        .rd_data    (mem_wr_data)
    );

    txbuf_drain #(.N(DEPTH)) drain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (drain_go),
        .load_mask(wset),
        .busy     (busy),
        .sel_idx  (sel_idx)
    );

    // Sticky status: doomed by conflict or overflow, renewed at commit/abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ok_q <= 1'b1;
        else if (is_end)                ok_q <= 1'b1;
        else if (conflict || overflow)  ok_q <= 1'b0;
    end

    // Registered response one cycle after an accepted op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= take && known;
            rsp_ok    <= (op == OP_ABORT) ? 1'b1 : still_ok;
            rsp_data  <= (is_acc && is_load) ? (hit ? hit_val : mem_rd_data) : '0;
        end
    end
endmodule

// File: rtl/txbuf_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for txbuf_ctrl, attached by bind. Assumes the processor
// presents op codes as defined in the brief.
module txbuf_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [2:0] op_code,
    input logic       busy,
    input logic       rsp_valid,
    input logic       rsp_ok,
    input logic       txn_ok
);
    // R7: a drain only ever starts alongside a successful commit response.
    assert_drain_after_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rsp_valid && rsp_ok));

    // R11: an op presented while draining produces no response.
    assert_stall_no_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid) |=> !rsp_valid);

    // R8: a failing response never comes with a drain.
    assert_fail_no_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> !busy);

    // R6: validating a doomed transaction answers false.
    assert_doomed_validate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_code == 3'd6 && !txn_ok) |=> (rsp_valid && !rsp_ok));

    // R9: abort never starts a write-back.
    assert_abort_no_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_code == 3'd5) |=> !busy);
endmodule

bind txbuf_ctrl txbuf_ctrl_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .busy     (busy),
    .rsp_valid(rsp_valid),
    .rsp_ok   (rsp_ok),
    .txn_ok   (ok_q)
);

// File: tb/txbuf_ctrl_tb_top.sv
`timescale 1ns/1ps
module txbuf_ctrl_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int N  = 4;
    localparam logic [2:0] C_LOAD = 3'd1, C_LOADX = 3'd2, C_STORE = 3'd3,
                           C_COMMIT = 3'd4, C_ABORT = 3'd5, C_VALID = 3'd6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_code = '0;
    logic [AW-1:0] op_addr = '0;
    logic [DW-1:0] op_wdata = '0;
    logic          op_ready, rsp_valid, rsp_ok;
    logic [DW-1:0] rsp_data;
    logic          snp_valid = 1'b0, snp_write = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [DW-1:0] mem_rd_data, mem_wr_data;
    logic          mem_wr_en, busy;

    txbuf_ctrl #(.AW(AW), .DW(DW), .DEPTH(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .op_wdata(op_wdata), .op_ready(op_ready),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .busy(busy)
    );

    function automatic logic [DW-1:0] init_val(int a);
        return DW'(a * 37 + 5);
    endfunction

    // Memory model with a write log.
    logic [DW-1:0] mem [256];
    logic [AW-1:0] log_addr [512];
    logic [DW-1:0] log_data [512];
    int            log_n = 0;
    assign mem_rd_data = mem[mem_rd_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 256; a++) mem[a] <= init_val(a);
        end else if (mem_wr_en) begin
            mem[mem_wr_addr]  <= mem_wr_data;
            log_addr[log_n]   <= mem_wr_addr;
            log_data[log_n]   <= mem_wr_data;
            log_n             <= log_n + 1;
        end
    end

    logic [DW-1:0] exp_mem [256];
    int n_chk = 0, n_fail = 0;
    logic got_v, got_ok;
    logic [DW-1:0] got_d;
    int cycles;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_addr = a; op_wdata = d;
        @(posedge clk); #1;
        got_v = rsp_valid; got_ok = rsp_ok; got_d = rsp_data;
        op_valid = 1'b0;
    endtask

    task automatic snoop(input logic w, input logic [AW-1:0] a);
        @(negedge clk);
        snp_valid = 1'b1; snp_write = w; snp_addr = a;
        @(posedge clk); #1;
        snp_valid = 1'b0;
    endtask

    task automatic wait_drain();
        cycles = 0;
        while (busy) begin
            @(posedge clk); #1;
            cycles++;
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) exp_mem[a] = init_val(a);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R12", "busy", busy, 0);
        check("R12", "rsp_valid", rsp_valid, 0);
        check("R12", "op_ready", op_ready, 1);
        check("R12", "mem_wr_en", mem_wr_en, 0);

        // Sweep: store count x snoop kind.
        for (int k = 1; k <= 3; k++) begin
            for (int kind = 0; kind < 6; kind++) begin
                int trial, base;
                logic [AW-1:0] ra;
                logic exp_ok;
                trial  = (k - 1) * 6 + kind;
                ra     = AW'(8 * trial + 2);
                exp_ok = (kind == 0) || (kind == 1) || (kind == 5);
                do_op(C_LOAD, ra, '0);
                check("R1", "load data", got_d, exp_mem[ra]);
                check("R1", "load rsp_valid", got_v, 1);
                for (int j = 0; j < k; j++) begin
                    do_op(C_STORE, ra + AW'(1 + j), DW'(16'h4000 + trial * 16 + j));
                    check("R3", "memory before commit", mem[ra + AW'(1 + j)], exp_mem[ra + AW'(1 + j)]);
                end
                do_op(C_LOAD, ra + AW'(1), '0);
                check("R4", "tentative load", got_d, DW'(16'h4000 + trial * 16));
                case (kind)
                    1: snoop(1'b0, ra);
                    2: snoop(1'b1, ra);
                    3: snoop(1'b0, ra + AW'(1));
                    4: snoop(1'b1, ra + AW'(1));
                    5: snoop(1'b1, ra + AW'(7));
                    default: ;
                endcase
                do_op(C_VALID, '0, '0);
                check("R6", "validate after snoop (R5)", got_ok, exp_ok);
                base = log_n;
                do_op(C_COMMIT, '0, '0);
                check(exp_ok ? "R7" : "R8", "commit rsp_ok", got_ok, exp_ok);
                wait_drain();
                check(exp_ok ? "R7" : "R8", "busy cycles", cycles, exp_ok ? k : 0);
                check(exp_ok ? "R7" : "R8", "write count", log_n - base, exp_ok ? k : 0);
                if (exp_ok) begin
                    for (int j = 0; j < k; j++) begin
                        check("R7", "drain order addr", log_addr[base + j], ra + AW'(1 + j));
                        check("R7", "drain data", log_data[base + j], DW'(16'h4000 + trial * 16 + j));
                        exp_mem[ra + AW'(1 + j)] = DW'(16'h4000 + trial * 16 + j);
                    end
                end
                for (int j = 0; j < k; j++)
                    check(exp_ok ? "R7" : "R8", "memory after commit",
                          mem[ra + AW'(1 + j)], exp_mem[ra + AW'(1 + j)]);
                do_op(C_VALID, '0, '0);
                check("R8", "fresh transaction live", got_ok, 1);
            end
        end

        // R2: load-exclusive joins the write set.
        begin
            int base;
            do_op(C_LOADX, 8'd200, '0);
            check("R2", "loadx data", got_d, exp_mem[200]);
            base = log_n;
            do_op(C_COMMIT, '0, '0);
            check("R2", "loadx commit ok", got_ok, 1);
            wait_drain();
            check("R2", "loadx write-back count", log_n - base, 1);
            check("R2", "loadx write-back addr", log_addr[base], 200);
            check("R2", "loadx write-back data", log_data[base], exp_mem[200]);
            do_op(C_LOADX, 8'd201, '0);
            snoop(1'b0, 8'd201);
            do_op(C_VALID, '0, '0);
            check("R2", "outside read of loadx address dooms (R5)", got_ok, 0);
            do_op(C_COMMIT, '0, '0);
            check("R8", "doomed commit", got_ok, 0);
            wait_drain();
            check("R8", "doomed commit busy", cycles, 0);
        end

        // R9: abort.
        do_op(C_STORE, 8'd210, 16'hBEEF);
        do_op(C_LOAD, 8'd210, '0);
        check("R4", "tentative before abort", got_d, 16'hBEEF);
        do_op(C_ABORT, '0, '0);
        check("R9", "abort rsp_ok", got_ok, 1);
        check("R9", "abort no busy", busy, 0);
        check("R9", "memory after abort", mem[210], exp_mem[210]);
        do_op(C_LOAD, 8'd210, '0);
        check("R9", "load after abort sees memory", got_d, exp_mem[210]);
        check("R9", "fresh after abort", got_ok, 1);
        do_op(C_ABORT, '0, '0);

        // R10: capacity with loads, then with stores.
        for (int i = 0; i < N; i++) begin
            do_op(C_LOAD, AW'(220 + i), '0);
            check("R10", "load within capacity", got_ok, 1);
        end
        do_op(C_LOAD, AW'(220 + N), '0);
        check("R10", "overflow load rsp_ok", got_ok, 0);
        check("R10", "overflow load data", got_d, exp_mem[220 + N]);
        do_op(C_VALID, '0, '0);
        check("R10", "validate after overflow", got_ok, 0);
        do_op(C_COMMIT, '0, '0);
        check("R10", "commit after overflow", got_ok, 0);
        for (int i = 0; i <= N; i++) do_op(C_STORE, AW'(240 + i), DW'(16'h7000 + i));
        check("R10", "overflow store rsp_ok", got_ok, 0);
        do_op(C_COMMIT, '0, '0);
        check("R10", "store overflow commit", got_ok, 0);
        wait_drain();
        for (int i = 0; i <= N; i++)
            check("R10", "memory after overflow", mem[240 + i], exp_mem[240 + i]);

        // R11: op during drain is ignored.
        begin
            int base;
            for (int i = 0; i < 3; i++) do_op(C_STORE, AW'(230 + i), DW'(16'h5000 + i));
            base = log_n;
            do_op(C_COMMIT, '0, '0);
            check("R11", "op_ready low while busy", op_ready, 0);
            do_op(C_STORE, 8'd233, 16'h1234);
            check("R11", "no response while busy", got_v, 0);
            wait_drain();
            check("R11", "drain length unaffected", log_n - base, 3);
            for (int i = 0; i < 3; i++) exp_mem[230 + i] = DW'(16'h5000 + i);
            base = log_n;
            do_op(C_COMMIT, '0, '0);
            check("R11", "next commit ok", got_ok, 1);
            wait_drain();
            check("R11", "ignored store not buffered", log_n - base, 0);
            check("R11", "ignored store memory", mem[233], exp_mem[233]);
            check("R7", "memory 232", mem[232], exp_mem[232]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule